// File: doc/BRIEF.md
# Banked GPIO Interrupt Detector

This block watches up to 32 general-purpose input pins and turns their state and transitions into interrupt requests for one or more processor cores. Every pin owns four condition bits: the pin is low, the pin is high, the pin fell, and the pin rose. Eight pins share one 32-bit word, so 32 pins fill four banks. The two level bits track the pin. The two edge bits are sticky and stay set until software clears them by writing a one.

Each core has its own enable and force words for every bank. The status word a core sees is the raw condition word combined with its force word and then masked by its enable word. A core's interrupt line is the OR of all of its status bits. Pin inputs are first resynchronised to the clock. Edges are then found by comparing successive synchronised samples. A small register port with a combinational read gives access to the raw, enable, force and status words.

Top module: `gpio_irq_detect`

## Requirements
- R1: Pin n occupies bank n/8, bits 4*(n%8) up to 4*(n%8)+3 of that bank. Within the nibble, bit 0 is level-low, bit 1 is level-high, bit 2 is falling-edge and bit 3 is rising-edge. Bits that belong to no pin read 0.
- R2: The level bits reflect a pin two clock edges after it changes, through a two-stage synchroniser.
- R3: An edge bit is set on the third clock edge after a pin change, and it stays set until a write of 1 reaches that bit in the raw word.
- R4: Writes to a raw word never change its level bits, and zero bits in that write leave the edge bits alone.
- R5: For each core and bank, the status word equals (raw OR force) AND enable, bit by bit. Status words are read-only, so writes to them are ignored.
- R6: Each core's interrupt output is high exactly when any of its status bits is set, and it is independent of the other cores.
- R7: Reset clears enable, force and the edge bits. No edge is recorded while the synchroniser refills after reset, even when pins are high during reset.
- R8: When a new edge and a clearing write hit the same bit on the same clock edge, the bit ends up set.
- R9: Word addresses with NB = number of banks and bank b: the raw words are at 0..NB-1. For core c, enable is at NB+3*NB*c+b, force at that address +NB, and status at that address +2*NB. Reads beyond the last word return 0 and writes there are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | NUM_PINS | Asynchronous pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| core_irq | output | NUM_CORES | Interrupt line per core |

## Verification
The bound checker checks on every cycle that each pin's two level bits are complementary, that unused bits stay zero, that a sticky edge bit only drops under a clearing write, that a core with no enable bits never interrupts while any forced and enabled bit does, and that unmapped reads return zero. The exact latency of the level and edge bits, the nibble layout, the suppression of edges after reset and the set-wins-over-clear collision can only be shown by the bench's timed scenarios. The same holds for the full status arithmetic under random pin, enable and force patterns.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
   localparam int WORD_W        = 32;
   localparam int COND_PER_PIN  = 4;
   localparam int PINS_PER_WORD = WORD_W / COND_PER_PIN;
   localparam int MAX_FLAT      = 128;

   // condition slot inside a pin nibble; position is decoded by software
   typedef enum int {
      COND_LVL_LO    = 0,
      COND_LVL_HI    = 1,
      COND_EDGE_FALL = 2,
      COND_EDGE_RISE = 3
   } cond_slot_e;

   typedef enum int {
      VIEW_ENABLE = 0,
      VIEW_FORCE  = 1,
      VIEW_STATUS = 2
   } view_sel_e;

   function automatic int bank_count(int np);
      return (np + PINS_PER_WORD - 1) / PINS_PER_WORD;
   endfunction

   function automatic logic [MAX_FLAT-1:0] pin_bit_mask(int np);
      logic [MAX_FLAT-1:0] m;
      for (int j = 0; j < MAX_FLAT; j++) m[j] = ((j / COND_PER_PIN) < np);
      return m;
   endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
   parameter int NUM_PINS    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] lvl,
   output logic [NUM_PINS-1:0] rise,
   output logic [NUM_PINS-1:0] fall
);
   localparam int ARM_AT = SYNC_STAGES + 1;
   localparam int CNT_W  = $clog2(ARM_AT + 1);

   logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];
   logic [NUM_PINS-1:0] prev_q;
   logic [CNT_W-1:0]    arm_cnt;
   logic                armed;

   assign armed = (arm_cnt == CNT_W'(ARM_AT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
         prev_q  <= '0;
         arm_cnt <= '0;
      end else begin
         stage_q[0] <= pin_in;
         for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
         prev_q <= stage_q[SYNC_STAGES-1];
         if (!armed) arm_cnt <= arm_cnt + 1'b1;
      end
   end

   assign lvl  = stage_q[SYNC_STAGES-1];
   assign rise = armed ? (lvl & ~prev_q) : '0;
   assign fall = armed ? (~lvl & prev_q) : '0;
endmodule

// File: rtl/gpio_irq_raw.sv
`timescale 1ns/1ps
module gpio_irq_raw
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int FLAT     = 128
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] lvl,
   input  logic [NUM_PINS-1:0] rise,
   input  logic [NUM_PINS-1:0] fall,
   input  logic [NUM_PINS-1:0] clr_rise,
   input  logic [NUM_PINS-1:0] clr_fall,
   output logic [FLAT-1:0]     raw
);
   localparam int USED = NUM_PINS * COND_PER_PIN;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic rise_q, fall_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
         end else begin
            // a fresh edge outranks a clear on the same cycle
            rise_q <= rise[p] | (rise_q & ~clr_rise[p]);
            fall_q <= fall[p] | (fall_q & ~clr_fall[p]);
         end
      end
      assign raw[p*COND_PER_PIN + COND_LVL_LO]    = ~lvl[p];
      assign raw[p*COND_PER_PIN + COND_LVL_HI]    =  lvl[p];
      assign raw[p*COND_PER_PIN + COND_EDGE_FALL] =  fall_q;
      assign raw[p*COND_PER_PIN + COND_EDGE_RISE] =  rise_q;
   end

   if (FLAT > USED) begin : g_pad
      assign raw[FLAT-1:USED] = '0;
   end
endmodule

// File: rtl/gpio_irq_view.sv
`timescale 1ns/1ps
module gpio_irq_view
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int NB       = 4,
   parameter int FLAT     = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAT-1:0]   raw,
   input  logic [NB-1:0]     en_we,
   input  logic [NB-1:0]     frc_we,
   input  logic [WORD_W-1:0] wdata,
   output logic [FLAT-1:0]   en,
   output logic [FLAT-1:0]   frc,
   output logic [FLAT-1:0]   stat,
   output logic              irq
);
   localparam logic [MAX_FLAT-1:0] MASK_W = pin_bit_mask(NUM_PINS);
   localparam logic [FLAT-1:0]     MASK   = MASK_W[FLAT-1:0];

   for (genvar b = 0; b < NB; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en[b*WORD_W +: WORD_W]  <= '0;
            frc[b*WORD_W +: WORD_W] <= '0;
         end else begin
            if (en_we[b])  en[b*WORD_W +: WORD_W]  <= wdata & MASK[b*WORD_W +: WORD_W];
            if (frc_we[b]) frc[b*WORD_W +: WORD_W] <= wdata & MASK[b*WORD_W +: WORD_W];
         end
      end
   end

   assign stat = (raw | frc) & en;
   assign irq  = |stat;
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int NUM_CORES   = 2,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PINS-1:0]  pins_in,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   output logic [NUM_CORES-1:0] core_irq
);
   localparam int NB     = bank_count(NUM_PINS);
   localparam int FLAT   = NB * WORD_W;
   localparam int BLK    = 3 * NB;
   localparam int NWORDS = NB + NUM_CORES * BLK;

   if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..32");
   end
   if (NUM_CORES < 1 || NUM_CORES > 4) begin : g_bad_cores
      $error("NUM_CORES must lie in 1..4");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 2..4");
   end
   if ((1 << ADDR_W) < NWORDS) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [NUM_PINS-1:0]       lvl, rise, fall, clr_rise, clr_fall;
   logic [FLAT-1:0]           raw_flat;
   logic [NUM_CORES*FLAT-1:0] en_all, frc_all, stat_all;
   logic [NB-1:0]             en_we  [NUM_CORES];
   logic [NB-1:0]             frc_we [NUM_CORES];

   gpio_irq_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_in(pins_in),
      .lvl(lvl), .rise(rise), .fall(fall)
   );

   // write-one-to-clear strobes for the sticky edge bits
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_clr
      localparam int BASE = (p % PINS_PER_WORD) * COND_PER_PIN;
      logic hit;
      assign hit         = reg_we && (int'(reg_addr) == p / PINS_PER_WORD);
      assign clr_fall[p] = hit && reg_wdata[BASE + COND_EDGE_FALL];
      assign clr_rise[p] = hit && reg_wdata[BASE + COND_EDGE_RISE];
   end

   gpio_irq_raw #(.NUM_PINS(NUM_PINS), .FLAT(FLAT)) u_raw (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall),
      .clr_rise(clr_rise), .clr_fall(clr_fall), .raw(raw_flat)
   );

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      for (genvar b = 0; b < NB; b++) begin : g_dec
         assign en_we[c][b]  = reg_we && (int'(reg_addr) == NB + c*BLK + VIEW_ENABLE*NB + b);
         assign frc_we[c][b] = reg_we && (int'(reg_addr) == NB + c*BLK + VIEW_FORCE*NB + b);
      end
      gpio_irq_view #(.NUM_PINS(NUM_PINS), .NB(NB), .FLAT(FLAT)) u_view (
         .clk(clk), .rst_n(rst_n), .raw(raw_flat),
         .en_we(en_we[c]), .frc_we(frc_we[c]), .wdata(reg_wdata),
         .en(en_all[c*FLAT +: FLAT]), .frc(frc_all[c*FLAT +: FLAT]),
         .stat(stat_all[c*FLAT +: FLAT]), .irq(core_irq[c])
      );
   end

   always_comb begin
      int idx, rel, cs, off, bs;
      reg_rdata = '0;
      idx = int'(reg_addr);
      rel = idx - NB;
      cs  = rel / BLK;
      off = rel % BLK;
      bs  = off % NB;
      if (idx < NB) begin
         reg_rdata = raw_flat[idx*WORD_W +: WORD_W];
      end else if (idx < NWORDS) begin
         case (off / NB)
            VIEW_ENABLE: reg_rdata = en_all[cs*FLAT + bs*WORD_W +: WORD_W];
            VIEW_FORCE:  reg_rdata = frc_all[cs*FLAT + bs*WORD_W +: WORD_W];
            default:     reg_rdata = stat_all[cs*FLAT + bs*WORD_W +: WORD_W];
         endcase
      end
   end
endmodule

// File: rtl/gpio_irq_chk.sv
`timescale 1ns/1ps
module gpio_irq_chk #(
   parameter int NUM_PINS  = 32,
   parameter int NUM_CORES = 2,
   parameter int ADDR_W    = 6,
   parameter int FLAT      = 128,
   parameter int NWORDS    = 28
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [FLAT-1:0]           raw,
   input logic [NUM_PINS-1:0]       clr_rise,
   input logic [NUM_PINS-1:0]       clr_fall,
   input logic [NUM_CORES*FLAT-1:0] en_all,
   input logic [NUM_CORES*FLAT-1:0] frc_all,
   input logic [NUM_CORES-1:0]      core_irq,
   input logic [ADDR_W-1:0]         reg_addr,
   input logic [31:0]               reg_rdata
);
   localparam int USED = NUM_PINS * 4;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      p_fall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         raw[4*p+2] && !clr_fall[p] |=> raw[4*p+2]);
      p_rise_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         raw[4*p+3] && !clr_rise[p] |=> raw[4*p+3]);
      p_level_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
         raw[4*p] != raw[4*p+1]);
   end

   if (FLAT > USED) begin : g_pad
      p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
         raw[FLAT-1:USED] == '0);
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      p_irq_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (en_all[c*FLAT +: FLAT] == '0) |-> !core_irq[c]);
      p_force_fires_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (|(frc_all[c*FLAT +: FLAT] & en_all[c*FLAT +: FLAT])) |-> core_irq[c]);
   end

   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(reg_addr) >= NWORDS) |-> (reg_rdata == '0));
endmodule

bind gpio_irq_detect gpio_irq_chk #(
   .NUM_PINS(NUM_PINS), .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W),
   .FLAT(FLAT), .NWORDS(NWORDS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .raw(raw_flat), .clr_rise(clr_rise),
   .clr_fall(clr_fall), .en_all(en_all), .frc_all(frc_all),
   .core_irq(core_irq), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/tb_gpio_irq_detect.sv
`timescale 1ns/1ps
module tb_gpio_irq_detect;
   localparam int NP = 32, NC = 2, AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pins_in = '1;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NC-1:0] core_irq;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   logic [31:0] m_pins, m_rise, m_fall;
   logic [31:0] m_en  [NC][4];
   logic [31:0] m_frc [NC][4];

   always #2.5 clk = ~clk;

   gpio_irq_detect #(.NUM_PINS(NP), .NUM_CORES(NC), .SYNC_STAGES(2), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .core_irq(core_irq)
   );

   task automatic step(); @(posedge clk); @(negedge clk); endtask
   task automatic wait_n(int n); for (int i = 0; i < n; i++) step(); endtask

   task automatic wr(int a, logic [31:0] d);
      reg_addr = AW'(a); reg_wdata = d; reg_we = 1'b1;
      step();
      reg_we = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      reg_addr = AW'(a); #1; d = reg_rdata;
   endtask

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic chk_rd(string tag, int a, logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   function automatic logic [31:0] exp_raw(int b);
      logic [31:0] w;
      for (int k = 0; k < 8; k++) begin
         int p = b*8 + k;
         w[4*k +: 4] = {m_rise[p], m_fall[p], m_pins[p], ~m_pins[p]};
      end
      return w;
   endfunction

   function automatic logic [31:0] exp_stat(int c, int b);
      return (exp_raw(b) | m_frc[c][b]) & m_en[c][b];
   endfunction

   function automatic logic [NC-1:0] exp_irq();
      logic [NC-1:0] r = '0;
      for (int c = 0; c < NC; c++)
         for (int b = 0; b < 4; b++) r[c] = r[c] | (|exp_stat(c, b));
      return r;
   endfunction

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [31:0] w;
      void'($urandom(32'h5eed_1234));
      // pins held high through reset: no edge may be recorded (R7)
      wait_n(4);
      rst_n = 1'b1;
      wait_n(6);
      for (int b = 0; b < 4; b++) chk_rd("R7 no edge after reset, level high R2", b, 32'h2222_2222);
      chk("R7 irq idle", 32'(core_irq), 32'h0);

      pins_in = '0;
      wait_n(4);
      for (int b = 0; b < 4; b++) chk_rd("R1 R3 falling edge plus level low", b, 32'h5555_5555);
      for (int b = 0; b < 4; b++) wr(b, 32'h4444_4444);
      for (int b = 0; b < 4; b++) chk_rd("R3 write one clears edge", b, 32'h1111_1111);
      wr(0, 32'hFFFF_FFFF);
      chk_rd("R4 level bits not clearable", 0, 32'h1111_1111);
      wr(1, 32'h0);
      chk_rd("R4 zero write no effect", 1, 32'h1111_1111);

      pins_in[13] = 1'b1;
      wait_n(4);
      chk_rd("R1 pin 13 nibble placement", 1, 32'h11A1_1111);
      chk_rd("R1 other bank untouched", 0, 32'h1111_1111);

      // latency of level and edge bits on pin 0
      pins_in[0] = 1'b1;
      step(); chk_rd("R2 level unchanged after one edge", 0, 32'h1111_1111);
      step(); chk_rd("R2 level after two edges", 0, 32'h1111_1112);
      step(); chk_rd("R3 edge after three edges", 0, 32'h1111_111A);

      // falling edge collides with a clear of both edge bits (R8)
      pins_in[0] = 1'b0;
      wait_n(2);
      wr(0, 32'h0000_000C);
      chk_rd("R8 new edge wins over clear", 0, 32'h1111_1115);

      wr(4, 32'h0000_0004);
      chk_rd("R5 status core0 bank0", 12, 32'h0000_0004);
      chk("R6 only core0 fires", 32'(core_irq), 32'h1);
      wr(23, 32'h8000_0000);
      wr(19, 32'h8000_0000);
      chk_rd("R5 force through enable core1 bank3", 27, 32'h8000_0000);
      chk("R6 both cores fire", 32'(core_irq), 32'h3);
      wr(12, 32'h0);
      chk_rd("R5 status is read only", 12, 32'h0000_0004);
      wr(0, 32'h0000_0004);
      chk_rd("R5 status follows clear", 12, 32'h0);
      chk("R6 core0 drops alone", 32'(core_irq), 32'h2);
      chk_rd("R9 unmapped read zero", 40, 32'h0);
      wr(40, 32'hFFFF_FFFF);
      chk_rd("R9 unmapped write ignored", 4, 32'h0000_0004);
      chk_rd("R9 force word address", 23, 32'h8000_0000);

      // second reset with pins low
      rst_n = 1'b0; pins_in = '0;
      wait_n(2);
      rst_n = 1'b1;
      wait_n(6);
      chk_rd("R7 enable reset", 4, 32'h0);
      chk_rd("R7 enable reset core1", 19, 32'h0);
      chk_rd("R7 force reset", 23, 32'h0);
      chk_rd("R7 edge bits reset", 0, 32'h1111_1111);

      m_pins = '0; m_rise = '0; m_fall = '0;
      for (int c = 0; c < NC; c++)
         for (int b = 0; b < 4; b++) begin m_en[c][b] = '0; m_frc[c][b] = '0; end

      for (int it = 0; it < 300; it++) begin
         int op = $urandom % 4;
         int c = $urandom % NC;
         int b = $urandom % 4;
         logic [31:0] v = $urandom;
         case (op)
            0: begin
               m_rise = m_rise | (~m_pins & v);
               m_fall = m_fall | (m_pins & ~v);
               m_pins = v;
               pins_in = v;
               wait_n(4);
            end
            1: begin
               v = v & $urandom;
               wr(4 + c*12 + b, v); m_en[c][b] = v;
            end
            2: begin
               v = v & $urandom & $urandom;
               wr(8 + c*12 + b, v); m_frc[c][b] = v;
            end
            default: begin
               wr(b, v);
               for (int k = 0; k < 8; k++) begin
                  if (v[4*k+2]) m_fall[b*8+k] = 1'b0;
                  if (v[4*k+3]) m_rise[b*8+k] = 1'b0;
               end
            end
         endcase
         chk_rd("R1 R3 R4 random raw word", b, exp_raw(b));
         for (int cc = 0; cc < NC; cc++)
            chk_rd("R5 random status word", 12 + cc*12 + b, exp_stat(cc, b));
         chk("R6 random irq", 32'(core_irq), 32'(exp_irq()));
      end

      done = 1;
      finish_run();
   end
endmodule